// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Slave Receiver

This block is a slave-only receiver for a two-wire serial bus in the I2C style. It is meant to load one control byte. It samples the bus clock and data lines with a faster system clock and finds the bus START and STOP conditions. It then shifts in a 7-bit address and a direction bit. When the address matches the block's own and the direction is write, it acknowledges by enabling an open-drain pull-down on the data line. It accepts one 8-bit data word and acknowledges that word as well.

Once the data acknowledge is over, the byte appears on a parallel output together with a strobe one system clock long. The block ignores read requests, foreign addresses and any bytes beyond the first, and it never drives the line while it ignores them. It cannot stretch the clock and has no master function. The system clock must run at least 8 times faster than the bus clock, so buses up to 400 kHz are covered.

Top module: `i2cw_slave`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe` is 0, `rx_valid` is 0 and `rx_data` is 0x00.
- R2: After a START, the first byte is taken MSB first on rising bus-clock edges: 7 address bits, then a direction bit where 0 means write. If the address equals `SLAVE_ADDR` (default 7'b1110110) and the direction is write, `sda_oe` is 1 across the whole high phase of the ninth bus clock.
- R3: When the address bits differ from `SLAVE_ADDR`, the block gives no acknowledge, leaves `sda_oe` at 0 until the next START and issues no `rx_valid`.
- R4: When the address matches but the direction bit is 1 (read), the block gives no acknowledge, keeps `sda_oe` at 0 for the rest of the transaction and issues no `rx_valid`.
- R5: After the address acknowledge, the next 8 bits are one data word, MSB first. The block acknowledges it on the ninth clock. After the falling bus-clock edge that ends that ninth clock, the word appears on `rx_data` with `rx_valid` high for exactly one system cycle. `rx_data` changes only in that cycle.
- R6: Only one data word is accepted per transaction. Further bytes before the STOP get no acknowledge and no strobe, and they leave `rx_data` unchanged.
- R7: A STOP (data rising while the bus clock is high) that comes before the data acknowledge completes throws away the partial byte: no strobe, and `rx_data` is unchanged.
- R8: A START (data falling while the bus clock is high), including a repeated START in the middle of a transaction, restarts address reception. A complete write that follows it is accepted.
- R9: `sda_oe` is asserted and released only while the synchronized bus clock is low. It is released after the falling edge that ends each ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 enables the open-drain pull-down on the data line |
| rx_data | output | 8 | Last accepted data word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
The address phase is swept over all 128 addresses with the write bit set. This shows that exactly one address pattern draws an acknowledge and that no other address reaches the data path. The data phase is swept over all 256 byte values to the matching address, which catches bit order, shift and commit-timing faults in every bit position. Separate cases cover a read request, a second byte, a STOP partway through a byte and a repeated START partway through a byte. Each of these separates "ignored and discarded" from "accepted", using the acknowledge, the strobe count and the held output word.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } i2cw_state_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // stages plus one history flop for edge detection; idle bus is high
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  // data edges are only bus conditions while the clock is high
  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;
endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'b1110110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  output logic              oe,
  output logic [BYTE_W-1:0] data,
  output logic              valid,
  output i2cw_state_e       state
);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] WR_FRAME = {SLAVE_ADDR, 1'b0};

  i2cw_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              oe_q, oe_d;
  logic              vld_q, vld_d;
  logic              dat_en;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    oe_d   = oe_q;
    dat_d  = dat_q;
    dat_en = 1'b0;
    vld_d  = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_DATA) begin
              st_d = ST_DATA_ACK;
              oe_d = 1'b1;
            end else if (sh_q == WR_FRAME) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (scl_fall) begin
            oe_d   = 1'b0;
            dat_d  = sh_q;
            dat_en = 1'b1;
            vld_d  = 1'b1;
            st_d   = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  assign oe    = oe_q;
  assign data  = dat_q;
  assign valid = vld_q;
  assign state = st_q;
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'b1110110,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int N_LINES = 2;
  localparam int L_SDA   = 0;
  localparam int L_SCL   = 1;

  logic [N_LINES-1:0] line_in;
  logic [N_LINES-1:0] line_lvl;
  logic [N_LINES-1:0] line_rise;
  logic [N_LINES-1:0] line_fall;
  logic               start_det;
  logic               stop_det;
  i2cw_state_e        fsm_state;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_in[g]),
      .lvl  (line_lvl[g]),
      .rise (line_rise[g]),
      .fall (line_fall[g])
    );
  end

  i2cw_cond u_cond (
    .scl_lvl  (line_lvl[L_SCL]),
    .sda_rise (line_rise[L_SDA]),
    .sda_fall (line_fall[L_SDA]),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cw_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (line_rise[L_SCL]),
    .scl_fall (line_fall[L_SCL]),
    .sda_lvl  (line_lvl[L_SDA]),
    .oe       (sda_oe),
    .data     (rx_data),
    .valid    (rx_valid),
    .state    (fsm_state)
  );
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk
  import i2cw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input i2cw_state_e       st
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R9
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_lvl); // R9
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid); // R5
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(st) == ST_DATA_ACK); // R5
  AST_NO_DRIVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe); // R4
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> st == ST_IDLE && !sda_oe); // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st == ST_ADDR && !sda_oe); // R8
endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .scl_lvl  (line_lvl[L_SCL]),
  .start_det(start_det),
  .stop_det (stop_det),
  .st       (fsm_state)
);

// File: tb/i2cw_slave_tb.sv
module i2cw_slave_tb;
  localparam int Q = 4;
  localparam int H = 8;
  localparam logic [6:0] MY_ADDR = 7'b1110110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic [7:0] rx_data;
  logic       rx_valid;
  wire        sda_line = m_sda & ~sda_oe;

  int  n_vec = 0;
  int  n_bad = 0;
  int  vcnt = 0;
  int  oe_cnt = 0;
  logic [7:0] last_v = 8'h00;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  i2cw_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt   <= vcnt + 1;
      last_v <= rx_data;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_n(Q); m_sda = 1'b1;
    wait_n(Q); scl = 1'b1;
    wait_n(H); m_sda = 1'b0;
    wait_n(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(Q); m_sda = 1'b0;
    wait_n(Q); scl = 1'b1;
    wait_n(H); m_sda = 1'b1;
    wait_n(H);
  endtask

  task automatic send_bit(input logic b);
    wait_n(Q); m_sda = b;
    wait_n(Q); scl = 1'b1;
    wait_n(H); scl = 1'b0;
  endtask

  // eight bits then the ninth clock; ack = line level while SCL high
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_n(Q); m_sda = 1'b1;
    wait_n(Q); scl = 1'b1;
    wait_n(H/2); ack = sda_line;
    wait_n(H/2); scl = 1'b0;
  endtask

  initial begin
    logic a1, a2;
    int   v0;
    logic [7:0] held;
    wait_n(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
    check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    check(rx_data == 8'h00, "R1 data", rx_data, 0);
    rst_n = 1'b1;
    wait_n(5);

    // R2/R3: sweep every address with the write bit
    for (int a = 0; a < 128; a++) begin
      v0 = vcnt;
      bus_start();
      send_byte({a[6:0], 1'b0}, a1);
      oe_cnt = 0;
      send_bit(1'b1); send_bit(1'b0);
      bus_stop();
      if (a[6:0] == MY_ADDR) begin
        check(a1 == 1'b0, "R2 addr ack", a1, 0);
      end else begin
        check(a1 == 1'b1, "R3 no ack", a1, 1);
        check(oe_cnt == 0, "R3 no drive", oe_cnt, 0);
      end
      check(vcnt == v0, "R3 no strobe", vcnt - v0, 0);
    end

    // R5: sweep every data value
    for (int d = 0; d < 256; d++) begin
      v0 = vcnt;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a1);
      send_byte(d[7:0], a2);
      wait_n(H);
      check(sda_oe == 1'b0, "R9 release", sda_oe, 0);
      bus_stop();
      check(a1 == 1'b0 && a2 == 1'b0, "R5 acks", {a1, a2}, 0);
      check(vcnt == v0 + 1, "R5 one strobe", vcnt - v0, 1);
      check(last_v == d[7:0] && rx_data == d[7:0], "R5 data", rx_data, d);
    end

    // R4: read request
    held = rx_data; v0 = vcnt;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a1);
    oe_cnt = 0;
    send_byte(8'h00, a2);
    bus_stop();
    check(a1 == 1'b1, "R4 read no ack", a1, 1);
    check(oe_cnt == 0 && a2 == 1'b1, "R4 no drive", oe_cnt, 0);
    check(vcnt == v0 && rx_data == held, "R4 no data", rx_data, held);

    // R6: second byte ignored
    v0 = vcnt;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a1);
    send_byte(8'hA5, a2);
    send_byte(8'h3C, a1);
    bus_stop();
    check(a1 == 1'b1, "R6 second byte no ack", a1, 1);
    check(vcnt == v0 + 1, "R6 one strobe", vcnt - v0, 1);
    check(rx_data == 8'hA5, "R6 data kept", rx_data, 8'hA5);

    // R7: stop mid-byte discards
    v0 = vcnt;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    wait_n(H);
    check(vcnt == v0, "R7 no strobe", vcnt - v0, 0);
    check(rx_data == 8'hA5, "R7 data held", rx_data, 8'hA5);
    check(sda_oe == 1'b0, "R7 released", sda_oe, 0);

    // R8: repeated start mid-byte, then full write
    v0 = vcnt;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a1);
    send_byte(8'hC3, a2);
    bus_stop();
    check(a1 == 1'b0 && a2 == 1'b0, "R8 acks after restart", {a1, a2}, 0);
    check(vcnt == v0 + 1, "R8 one strobe", vcnt - v0, 1);
    check(rx_data == 8'hC3, "R8 data", rx_data, 8'hC3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule